// File: doc/BRIEF.md
# Eight-bit ALU with branch condition evaluator

This unit is the single combinational execute stage of a small 8-bit core. It takes an opcode byte whose immediate-select bits have already been removed, together with two 8-bit operands. It produces one of two things: an 8-bit arithmetic or logic result, or a one-bit decision on whether a conditional branch is taken. The opcode space holds both groups. Compute operations sit at the bottom of the byte. The six comparison predicates form their own group that starts at 32.

The surrounding core uses a two-bit class output to choose its next step. It writes the result back when the class is compute, redirects the program counter when the class is condition and the taken flag is high, and handles every other opcode itself. The unit has no clock and no state. No data stream passes through it, so it has no handshake: operands go in and results come out in the same cycle.

Top module: `alu_branch_unit`

## Requirements
- R1: Opcode 0 gives (a + b) mod 256 and opcode 1 gives (a - b) mod 256.
- R2: Opcode 2 gives a AND b, opcode 3 gives a OR b and opcode 5 gives a XOR b, bit by bit.
- R3: Opcode 4 gives the bitwise inverse of a. Operand b has no effect on the result.
- R4: Opcode 6 shifts a right by b places and opcode 7 shifts a left by b places. Both shifts are logical and fill with zeros. Any b of 8 or more gives 0.
- R5: Opcode 10 gives the low 8 bits of the product a * b.
- R6: Opcodes 32, 33, 34, 35, 36 and 37 set taken when a is equal to, not equal to, less than, less than or equal to, greater than, or greater than or equal to b. All six compare a and b as unsigned numbers.
- R7: The class output is 2'b01 for opcodes 0 to 7 and 10, 2'b10 for opcodes 32 to 37, and 2'b00 for every other opcode. It is never 2'b11.
- R8: The taken output is 0 whenever the class is not 2'b10, and the result output is 0 whenever the class is not 2'b01.
- R9: Opcodes 8, 9, 11 to 31 and 38 to 255 are class 2'b00, with result 0 and taken 0, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 8 | Opcode byte, with the immediate-select bits removed |
| a | input | 8 | First operand |
| b | input | 8 | Second operand (also the shift count) |
| result | output | 8 | Compute result; 0 when the class is not compute |
| taken | output | 1 | Branch decision; 0 when the class is not condition |
| op_class | output | 2 | 01 compute, 10 condition, 00 other |

## Verification
The in-line checks assume that every input bit holds a known value. Each check is skipped while any operand or opcode bit is unknown. The checks also assume that the three inputs change together, between the points where the outputs are read. The bench therefore drives op, a and b in one step on the falling clock edge and samples the outputs a nanosecond later. Its sweeps choose operands at the wrap, sign and shift-count boundaries: 0, 1, 7, 8, 0x7F, 0x80 and 0xFF.

// File: rtl/abu_pkg.sv
package abu_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned OP_W   = 8;

  typedef enum logic [1:0] {
    CLS_OTHER   = 2'b00,
    CLS_COMPUTE = 2'b01,
    CLS_COND    = 2'b10
  } op_class_e;

  localparam logic [OP_W-1:0] OPC_ADD  = 8'd0;
  localparam logic [OP_W-1:0] OPC_SUB  = 8'd1;
  localparam logic [OP_W-1:0] OPC_AND  = 8'd2;
  localparam logic [OP_W-1:0] OPC_OR   = 8'd3;
  localparam logic [OP_W-1:0] OPC_NOT  = 8'd4;
  localparam logic [OP_W-1:0] OPC_XOR  = 8'd5;
  localparam logic [OP_W-1:0] OPC_SHR  = 8'd6;
  localparam logic [OP_W-1:0] OPC_SHL  = 8'd7;
  localparam logic [OP_W-1:0] OPC_MUL  = 8'd10;
  localparam logic [OP_W-1:0] OPC_CBASE = 8'd32;
  localparam int unsigned     N_PRED   = 6;

  // arithmetic selector for the arithmetic slice
  typedef enum logic [1:0] {
    AR_ADD = 2'b00,
    AR_SUB = 2'b01,
    AR_MUL = 2'b10
  } arith_sel_e;

endpackage

// File: rtl/abu_arith.sv
module abu_arith
  import abu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  arith_sel_e   sel,
  output logic [W-1:0] y
);

  logic [W-1:0] sum_w;
  logic [W-1:0] diff_w;
  logic [W-1:0] prod_w;

  always_comb begin
    sum_w  = a + b;
    diff_w = a - b;
    prod_w = W'(a * b);
  end

  always_comb begin
    unique case (sel)
      AR_ADD:  y = sum_w;
      AR_SUB:  y = diff_w;
      AR_MUL:  y = prod_w;
      default: y = '0;
    endcase
  end

  // R1: the wrapped difference added back to b must return a
  always_comb begin
    if (!$isunknown({a, b})) begin
      a_r1_sub_inverts_add: assert (W'(diff_w + b) == a)
        else $error("a_r1_sub_inverts_add");
    end
  end

  // R5: multiplying by one keeps the other operand
  always_comb begin
    if (!$isunknown({a, b}) && b == W'(1)) begin
      a_r5_mul_identity: assert (prod_w == a)
        else $error("a_r5_mul_identity");
    end
  end

endmodule

// File: rtl/abu_logic_shift.sv
module abu_logic_shift
  import abu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   fn,
  output logic [W-1:0] y
);

  localparam int unsigned SH_W = $clog2(W);

  logic         over_range;
  logic [SH_W-1:0] amt;
  logic [W-1:0] shr_w;
  logic [W-1:0] shl_w;

  always_comb begin
    over_range = |b[W-1:SH_W];
    amt        = b[SH_W-1:0];
    shr_w      = over_range ? '0 : (a >> amt);
    shl_w      = over_range ? '0 : (a << amt);
  end

  always_comb begin
    unique case (fn)
      3'd2:    y = a & b;
      3'd3:    y = a | b;
      3'd4:    y = ~a;
      3'd5:    y = a ^ b;
      3'd6:    y = shr_w;
      3'd7:    y = shl_w;
      default: y = '0;
    endcase
  end

  // R4: an out-of-range count empties either shift
  always_comb begin
    if (!$isunknown({a, b, fn}) && (fn == 3'd6 || fn == 3'd7) && b >= W) begin
      a_r4_wide_shift_zero: assert (y == '0)
        else $error("a_r4_wide_shift_zero");
    end
  end

  // R3: inverse of a never shares a set bit with a
  always_comb begin
    if (!$isunknown({a, b, fn}) && fn == 3'd4) begin
      a_r3_not_disjoint: assert ((y & a) == '0 && (y | a) == '1)
        else $error("a_r3_not_disjoint");
    end
  end

endmodule

// File: rtl/abu_cond.sv
module abu_cond
  import abu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   pred,
  output logic         hit
);

  logic [N_PRED-1:0] vec;
  logic is_eq;
  logic is_lt;

  always_comb begin
    is_eq = (a == b);
    is_lt = (a < b);
  end

  // predicate vector, index order follows opcode order from the base
  always_comb begin
    vec[0] = is_eq;
    vec[1] = !is_eq;
    vec[2] = is_lt;
    vec[3] = is_lt | is_eq;
    vec[4] = !(is_lt | is_eq);
    vec[5] = !is_lt;
  end

  always_comb begin
    hit = (int'(pred) < N_PRED) ? vec[pred] : 1'b0;
  end

  // R6: exactly one of less, equal, greater holds
  always_comb begin
    if (!$isunknown({a, b})) begin
      a_r6_trichotomy: assert ($countones({vec[2], vec[0], vec[4]}) == 1)
        else $error("a_r6_trichotomy");
    end
  end

endmodule

// File: rtl/alu_branch_unit.sv
module alu_branch_unit
  import abu_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned OW = OP_W
) (
  input  logic [OW-1:0] op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  result,
  output logic          taken,
  output logic [1:0]    op_class
);

  op_class_e  cls;
  arith_sel_e ar_sel;
  logic       use_arith;
  logic [W-1:0] ar_y;
  logic [W-1:0] ls_y;
  logic       cond_hit;
  logic [OW-1:0] cond_idx;

  // opcode decode
  always_comb begin
    cond_idx = op - OW'(OPC_CBASE);
    if (op <= OW'(OPC_SHL) || op == OW'(OPC_MUL))
      cls = CLS_COMPUTE;
    else if (op >= OW'(OPC_CBASE) && cond_idx < OW'(N_PRED))
      cls = CLS_COND;
    else
      cls = CLS_OTHER;

    use_arith = (op == OW'(OPC_ADD)) || (op == OW'(OPC_SUB)) || (op == OW'(OPC_MUL));
    if (op == OW'(OPC_MUL))      ar_sel = AR_MUL;
    else if (op == OW'(OPC_SUB)) ar_sel = AR_SUB;
    else                         ar_sel = AR_ADD;
  end

  abu_arith #(.W(W)) u_arith (
    .a   (a),
    .b   (b),
    .sel (ar_sel),
    .y   (ar_y)
  );

  abu_logic_shift #(.W(W)) u_lsh (
    .a  (a),
    .b  (b),
    .fn (op[2:0]),
    .y  (ls_y)
  );

  abu_cond #(.W(W)) u_cond (
    .a    (a),
    .b    (b),
    .pred (cond_idx[2:0]),
    .hit  (cond_hit)
  );

  // output steering
  always_comb begin
    op_class = cls;
    if (cls == CLS_COMPUTE)
      result = use_arith ? ar_y : ls_y;
    else
      result = '0;
    taken = (cls == CLS_COND) ? cond_hit : 1'b0;
  end

  // R7: class is one-hot or zero
  always_comb begin
    if (!$isunknown(op)) begin
      a_r7_class_legal: assert ($onehot0(op_class))
        else $error("a_r7_class_legal");
    end
  end

  // R8: taken only for condition opcodes, result only for compute opcodes
  always_comb begin
    if (!$isunknown({op, a, b})) begin
      a_r8_taken_gated: assert (!(taken && op_class != 2'b10))
        else $error("a_r8_taken_gated");
      a_r8_result_gated: assert (op_class == 2'b01 || result == '0)
        else $error("a_r8_result_gated");
    end
  end

endmodule

// File: tb/alu_branch_unit_test.sv
module alu_branch_unit_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic [7:0] op, a, b;
  logic [7:0] result;
  logic       taken;
  logic [1:0] op_class;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  alu_branch_unit uut (
    .op(op), .a(a), .b(b),
    .result(result), .taken(taken), .op_class(op_class)
  );

  // vector: op, a, b, exp_result, exp_taken, exp_class
  localparam int NV = 26;
  localparam logic [34:0] VEC [NV] = '{
    {8'd0,  8'd200, 8'd100, 8'd44,  1'b0, 2'd1},
    {8'd0,  8'd255, 8'd1,   8'd0,   1'b0, 2'd1},
    {8'd1,  8'd5,   8'd10,  8'd251, 1'b0, 2'd1},
    {8'd2,  8'hCC,  8'hAA,  8'h88,  1'b0, 2'd1},
    {8'd3,  8'hCC,  8'hAA,  8'hEE,  1'b0, 2'd1},
    {8'd5,  8'hCC,  8'hAA,  8'h66,  1'b0, 2'd1},
    {8'd4,  8'h5A,  8'hFF,  8'hA5,  1'b0, 2'd1},
    {8'd4,  8'h5A,  8'h00,  8'hA5,  1'b0, 2'd1},
    {8'd6,  8'h80,  8'd3,   8'h10,  1'b0, 2'd1},
    {8'd7,  8'h81,  8'd1,   8'h02,  1'b0, 2'd1},
    {8'd6,  8'hFF,  8'd8,   8'h00,  1'b0, 2'd1},
    {8'd7,  8'hFF,  8'd200, 8'h00,  1'b0, 2'd1},
    {8'd7,  8'h01,  8'd7,   8'h80,  1'b0, 2'd1},
    {8'd10, 8'd16,  8'd17,  8'd16,  1'b0, 2'd1},
    {8'd10, 8'd15,  8'd15,  8'd225, 1'b0, 2'd1},
    {8'd32, 8'd7,   8'd7,   8'd0,   1'b1, 2'd2},
    {8'd33, 8'd7,   8'd7,   8'd0,   1'b0, 2'd2},
    {8'd34, 8'd3,   8'd200, 8'd0,   1'b1, 2'd2},
    {8'd35, 8'd200, 8'd200, 8'd0,   1'b1, 2'd2},
    {8'd36, 8'd200, 8'd3,   8'd0,   1'b1, 2'd2},
    {8'd37, 8'd3,   8'd200, 8'd0,   1'b0, 2'd2},
    {8'd8,  8'd9,   8'd9,   8'd0,   1'b0, 2'd0},
    {8'd9,  8'd1,   8'd2,   8'd0,   1'b0, 2'd0},
    {8'd31, 8'd4,   8'd4,   8'd0,   1'b0, 2'd0},
    {8'd38, 8'd4,   8'd4,   8'd0,   1'b0, 2'd0},
    {8'd255,8'd4,   8'd4,   8'd0,   1'b0, 2'd0}
  };

  function automatic string req_of(input logic [7:0] o);
    case (o)
      8'd0, 8'd1:        return "R1";
      8'd2, 8'd3, 8'd5:  return "R2";
      8'd4:              return "R3";
      8'd6, 8'd7:        return "R4";
      8'd10:             return "R5";
      default: return (o >= 8'd32 && o <= 8'd37) ? "R6" : "R9";
    endcase
  endfunction

  // independent reference model
  task automatic model(input logic [7:0] o, input logic [7:0] x, input logic [7:0] y,
                       output logic [7:0] r, output logic t, output logic [1:0] c);
    int s;
    r = 8'd0; t = 1'b0; c = 2'd0;
    s = 0;
    case (o)
      8'd0:  begin r = 8'((int'(x) + int'(y)) % 256); c = 2'd1; end
      8'd1:  begin r = 8'((int'(x) - int'(y) + 256) % 256); c = 2'd1; end
      8'd2:  begin r = x & y; c = 2'd1; end
      8'd3:  begin r = x | y; c = 2'd1; end
      8'd4:  begin r = 8'hFF - x; c = 2'd1; end
      8'd5:  begin r = x ^ y; c = 2'd1; end
      8'd6:  begin s = int'(x); for (int i = 0; i < int'(y) && i < 9; i++) s = s / 2; r = 8'(s); c = 2'd1; end
      8'd7:  begin s = int'(x); for (int i = 0; i < int'(y) && i < 9; i++) s = (s * 2) % 256; r = 8'(s); c = 2'd1; end
      8'd10: begin r = 8'((int'(x) * int'(y)) % 256); c = 2'd1; end
      8'd32: begin t = (x == y); c = 2'd2; end
      8'd33: begin t = (x != y); c = 2'd2; end
      8'd34: begin t = (int'(x) < int'(y)); c = 2'd2; end
      8'd35: begin t = (int'(x) <= int'(y)); c = 2'd2; end
      8'd36: begin t = (int'(x) > int'(y)); c = 2'd2; end
      8'd37: begin t = (int'(x) >= int'(y)); c = 2'd2; end
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s %s op=%0d a=%0d b=%0d actual=%0d expected=%0d",
               tag, what, op, a, b, got, exp);
    end
  endtask

  task automatic apply(input logic [7:0] o, input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    op = o; a = x; b = y;
    #1;
  endtask

  task automatic check_all(input string tag, input logic [7:0] er, input logic et, input logic [1:0] ec);
    check(tag, "result", int'(result), int'(er));
    check(tag, "taken", int'(taken), int'(et));
    check("R7", "class", int'(op_class), int'(ec));
  endtask

  initial begin
    logic [7:0] er; logic et; logic [1:0] ec;
    logic [7:0] pts [7] = '{8'd0, 8'd1, 8'd7, 8'd8, 8'h7F, 8'h80, 8'hFF};
    op = 8'd0; a = 8'd0; b = 8'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset state: idle inputs give a zero add
    apply(8'd0, 8'd0, 8'd0);
    check_all("R1", 8'd0, 1'b0, 2'd1);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][34:27], VEC[i][26:19], VEC[i][18:11]);
      check_all(req_of(VEC[i][34:27]), VEC[i][10:3], VEC[i][2], VEC[i][1:0]);
    end

    // R3: b has no effect on NOT
    for (int j = 0; j < 7; j++) begin
      apply(8'd4, 8'h3C, pts[j]);
      check("R3", "not_ignores_b", int'(result), 8'hC3);
    end

    // R8 / R9: sweep of opcodes 0..63 and boundary operands against the model
    for (int o = 0; o < 64; o++)
      for (int x = 0; x < 7; x++)
        for (int y = 0; y < 7; y++) begin
          apply(8'(o), pts[x], pts[y]);
          model(8'(o), pts[x], pts[y], er, et, ec);
          check_all((ec == 2'd0) ? "R9" : "R8", er, et, ec);
        end

    // R9: high opcodes
    for (int o = 64; o < 256; o += 17) begin
      apply(8'(o), 8'hFF, 8'hFF);
      check_all("R9", 8'd0, 1'b0, 2'd0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule